// File: doc/BRIEF.md
# Reciprocal Frequency Counter Gate Engine

This block runs the timing core of a reciprocal frequency meter. After a start pulse it waits for a rising edge of the measured signal. That edge opens the measurement gate. While the gate is open, the block counts two things: the edges of the measured signal and the cycles of the reference clock. The gate closes on the first input edge that arrives after a minimum gate interval has elapsed. Because the gate both opens and closes on input edges, the count always covers a whole number of input periods. The classic plus-or-minus-one error of a free-running gate does not appear.

Downstream arithmetic divides the event count by the reference count, scaled by the prescaler factor reported here. The prescaler factor is 10 on the low-frequency path and 256 on the high-frequency path. The event input comes from the selected prescaler and may be asynchronous to the reference clock, so it is resynchronized inside the block.

There are two watchdogs, and each ends a stalled measurement with a no-signal indication and zeroed counts:
- The first limits how long the block waits for the opening edge.
- The second limits how long the block waits for the closing edge once the minimum gate has passed.

After either watchdog fires, the block re-arms by itself, so that a removed signal shows zeros and a returning signal is measured again without a new start.

Top module: `recip_gate_engine`

## Requirements
- R1: After synchronous reset, `done` and `no_signal` are 0, both counts are 0, `psc_hf` is 0 and `psc_factor` is 10.
- R2: The gate opens only on a rising edge of `evt_in` (passed through a two-stage synchronizer) while the block is armed. The opening edge itself is not counted. Every later rising edge up to and including the closing edge adds one to `evt_count`.
- R3: The gate closes on the first rising edge at which the gate length reaches at least `MIN_GATE_CYC` reference cycles. For a periodic input of period P cycles, the results are `evt_count = ceil(MIN_GATE_CYC/P)` and `ref_count = evt_count*P`.
- R4: At the end of a successful measurement, `done` is high for exactly one cycle. Both counts then hold their values until the next start.
- R5: A `start` pulse in any state clears both counts in the following cycle and re-arms the block. It also clears `no_signal`.
- R6: If no opening edge is seen, `no_signal` rises exactly `FIRST_TO_CYC` cycles after the clock edge that sampled `start`. The counts read 0 and the block re-arms on its own.
- R7: If the gate is open and no closing edge arrives, the block gives up when the gate has lasted `MIN_GATE_CYC + LATE_TO_CYC` cycles. At that point `no_signal` rises, the counts read 0 and the block re-arms.
- R8: `hf_sel` is sampled whenever the block arms, either on start or on re-arm after a timeout. A 1 gives `psc_hf = 1` with `psc_factor = 256`. A 0 gives `psc_hf = 0` with `psc_factor = 10`. Changes of `hf_sel` at other times have no effect.
- R9: `no_signal` stays high until the next completed measurement or the next `start`.
- R10: The reference count never exceeds `MIN_GATE_CYC + LATE_TO_CYC`, and the event count never exceeds the reference count, so neither counter wraps.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Reference clock (10 MHz nominal) |
| rst | input | 1 | Synchronous active-high reset |
| evt_in | input | 1 | Prescaled event signal, asynchronous |
| hf_sel | input | 1 | High-frequency path present (RF detector level) |
| start | input | 1 | Begin a new measurement |
| evt_count | output | EVT_W | Whole input periods inside the gate |
| ref_count | output | REF_W | Reference cycles inside the gate |
| psc_hf | output | 1 | Prescaler code: 0 divide-by-10, 1 divide-by-256 |
| psc_factor | output | 9 | Prescaler factor, 10 or 256 |
| done | output | 1 | One-cycle completion pulse |
| no_signal | output | 1 | Last attempt timed out; counts read zero |

## Verification
The bench runs a small configuration and sweeps the input period over every value from 2 cycles up to beyond the minimum gate. This separates several errors in the closing rule:
- closing one edge too early;
- closing one edge too late;
- counting the opening edge.

The sweep alternates the range select, so a wrong factor mapping or a wrong latch point shows up. Three further patterns are applied:
- A silent input is used to time the first-edge watchdog to the exact cycle.
- A single isolated edge is used to time the closing-edge watchdog.
- A start issued in the middle of an open gate shows whether a restart fully clears the counts and re-samples the range.

// File: rtl/recip_pkg.sv
package recip_pkg;

    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_ARM  = 2'd1,
        ST_GATE = 2'd2
    } gate_state_e;

    typedef enum logic {
        RANGE_LF = 1'b0,
        RANGE_HF = 1'b1
    } range_e;

    localparam int unsigned LF_DIV   = 10;
    localparam int unsigned HF_DIV   = 256;
    localparam int unsigned FACTOR_W = 9;

    typedef struct packed {
        logic clear;
        logic run;
    } cnt_ctrl_t;

    function automatic logic [FACTOR_W-1:0] range_factor(range_e r);
        return (r == RANGE_HF) ? FACTOR_W'(HF_DIV) : FACTOR_W'(LF_DIV);
    endfunction

endpackage

// File: rtl/recip_edge_sync.sv
module recip_edge_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst,
    input  logic async_in,
    output logic rise
);
    logic [STAGES-1:0] chain_q;
    logic              prev_q;

    genvar i;
    generate
        for (i = 0; i < STAGES; i++) begin : g_stage
            if (i == 0) begin : g_first
                always_ff @(posedge clk) begin
                    if (rst) chain_q[0] <= 1'b0;
                    else     chain_q[0] <= async_in;
                end
            end else begin : g_next
                always_ff @(posedge clk) begin
                    if (rst) chain_q[i] <= 1'b0;
                    else     chain_q[i] <= chain_q[i-1];
                end
            end
        end
    endgenerate

    always_ff @(posedge clk) begin
        if (rst) prev_q <= 1'b0;
        else     prev_q <= chain_q[STAGES-1];
    end

    assign rise = chain_q[STAGES-1] & ~prev_q;

    assert_rise_single_R2: assert property (@(posedge clk) disable iff (rst)
        rise |=> !rise);

endmodule

// File: rtl/recip_counters.sv
module recip_counters
    import recip_pkg::*;
#(
    parameter int REF_W   = 25,
    parameter int EVT_W   = 25,
    parameter int REF_MAX = 25_000_000
) (
    input  logic             clk,
    input  logic             rst,
    input  cnt_ctrl_t        ctrl,
    input  logic             rise,
    output logic [REF_W-1:0] ref_cnt,
    output logic [EVT_W-1:0] evt_cnt
);
    always_ff @(posedge clk) begin
        if (rst || ctrl.clear) begin
            ref_cnt <= '0;
            evt_cnt <= '0;
        end else if (ctrl.run) begin
            ref_cnt <= ref_cnt + 1'b1;
            if (rise) evt_cnt <= evt_cnt + 1'b1;
        end
    end

    assert_clear_zero_R5: assert property (@(posedge clk) disable iff (rst)
        ctrl.clear |=> (ref_cnt == '0 && evt_cnt == '0));

    assert_ref_bound_R10: assert property (@(posedge clk) disable iff (rst)
        32'(ref_cnt) <= 32'(REF_MAX));

    assert_evt_le_ref_R10: assert property (@(posedge clk) disable iff (rst)
        32'(evt_cnt) <= 32'(ref_cnt));

endmodule

// File: rtl/recip_gate_fsm.sv
module recip_gate_fsm
    import recip_pkg::*;
#(
    parameter int MIN_GATE_CYC = 10_000_000,
    parameter int FIRST_TO_CYC = 3_500_000,
    parameter int LATE_TO_CYC  = 15_000_000,
    parameter int REF_W        = 25
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             start,
    input  logic             hf_sel,
    input  logic             rise,
    input  logic [REF_W-1:0] ref_cnt,
    output cnt_ctrl_t        ctrl,
    output logic             done,
    output logic             no_signal,
    output range_e           range_q
);
    localparam int ARM_W = $clog2(FIRST_TO_CYC + 1);
    localparam logic [REF_W-1:0] MIN_LIM  = REF_W'(MIN_GATE_CYC);
    localparam logic [REF_W-1:0] LATE_LIM = REF_W'(MIN_GATE_CYC + LATE_TO_CYC);
    localparam logic [ARM_W-1:0] ARM_LAST = ARM_W'(FIRST_TO_CYC - 1);

    gate_state_e      state_q;
    logic [ARM_W-1:0] arm_tmr_q;
    logic [REF_W-1:0] ref_next;
    logic             close_now, late_abort, first_abort, abort;

    assign ref_next    = ref_cnt + 1'b1;
    assign close_now   = (state_q == ST_GATE) && rise && (ref_next >= MIN_LIM);
    assign late_abort  = (state_q == ST_GATE) && !rise && (ref_next == LATE_LIM);
    assign first_abort = (state_q == ST_ARM) && !rise && (arm_tmr_q == ARM_LAST);
    assign abort       = !start && (late_abort || first_abort);

    assign ctrl.clear = start || abort;
    assign ctrl.run   = (state_q == ST_GATE);

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q   <= ST_IDLE;
            arm_tmr_q <= '0;
            done      <= 1'b0;
            no_signal <= 1'b0;
            range_q   <= RANGE_LF;
        end else begin
            done <= 1'b0;
            if (start) begin
                state_q   <= ST_ARM;
                arm_tmr_q <= '0;
                no_signal <= 1'b0;
                range_q   <= hf_sel ? RANGE_HF : RANGE_LF;
            end else begin
                case (state_q)
                    ST_ARM: begin
                        if (rise) begin
                            state_q <= ST_GATE;
                        end else if (first_abort) begin
                            no_signal <= 1'b1;
                            arm_tmr_q <= '0;
                            range_q   <= hf_sel ? RANGE_HF : RANGE_LF;
                        end else begin
                            arm_tmr_q <= arm_tmr_q + 1'b1;
                        end
                    end
                    ST_GATE: begin
                        if (close_now) begin
                            done      <= 1'b1;
                            no_signal <= 1'b0;
                            state_q   <= ST_IDLE;
                        end else if (late_abort) begin
                            no_signal <= 1'b1;
                            arm_tmr_q <= '0;
                            state_q   <= ST_ARM;
                            range_q   <= hf_sel ? RANGE_HF : RANGE_LF;
                        end
                    end
                    default: state_q <= ST_IDLE;
                endcase
            end
        end
    end

    assert_done_pulse_R4: assert property (@(posedge clk) disable iff (rst)
        done |=> !done);

    assert_arm_window_R6: assert property (@(posedge clk) disable iff (rst)
        (state_q == ST_ARM) |-> (32'(arm_tmr_q) < 32'(FIRST_TO_CYC)));

    assert_range_held_R8: assert property (@(posedge clk) disable iff (rst)
        (!start && !abort) |=> $stable(range_q));

    assert_nosig_sticky_R9: assert property (@(posedge clk) disable iff (rst)
        (no_signal && !start && !close_now) |=> no_signal);

endmodule

// File: rtl/recip_gate_engine.sv
module recip_gate_engine
    import recip_pkg::*;
#(
    parameter int MIN_GATE_CYC = 10_000_000,
    parameter int FIRST_TO_CYC = 3_500_000,
    parameter int LATE_TO_CYC  = 15_000_000,
    parameter int SYNC_STAGES  = 2,
    parameter int REF_W        = $clog2(MIN_GATE_CYC + LATE_TO_CYC + 1),
    parameter int EVT_W        = REF_W
) (
    input  logic                clk,
    input  logic                rst,
    input  logic                evt_in,
    input  logic                hf_sel,
    input  logic                start,
    output logic [EVT_W-1:0]    evt_count,
    output logic [REF_W-1:0]    ref_count,
    output logic                psc_hf,
    output logic [FACTOR_W-1:0] psc_factor,
    output logic                done,
    output logic                no_signal
);
    logic      rise;
    cnt_ctrl_t ctrl;
    range_e    range_q;

    recip_edge_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk      (clk),
        .rst      (rst),
        .async_in (evt_in),
        .rise     (rise)
    );

    recip_gate_fsm #(
        .MIN_GATE_CYC (MIN_GATE_CYC),
        .FIRST_TO_CYC (FIRST_TO_CYC),
        .LATE_TO_CYC  (LATE_TO_CYC),
        .REF_W        (REF_W)
    ) u_fsm (
        .clk       (clk),
        .rst       (rst),
        .start     (start),
        .hf_sel    (hf_sel),
        .rise      (rise),
        .ref_cnt   (ref_count),
        .ctrl      (ctrl),
        .done      (done),
        .no_signal (no_signal),
        .range_q   (range_q)
    );

    recip_counters #(
        .REF_W   (REF_W),
        .EVT_W   (EVT_W),
        .REF_MAX (MIN_GATE_CYC + LATE_TO_CYC)
    ) u_cnt (
        .clk     (clk),
        .rst     (rst),
        .ctrl    (ctrl),
        .rise    (rise),
        .ref_cnt (ref_count),
        .evt_cnt (evt_count)
    );

    assign psc_hf     = (range_q == RANGE_HF);
    assign psc_factor = range_factor(range_q);

    assert_hold_after_done_R4: assert property (@(posedge clk) disable iff (rst)
        (done && !start) |=> ($stable(ref_count) && $stable(evt_count)));

    assert_min_gate_R3: assert property (@(posedge clk) disable iff (rst)
        done |-> (32'(ref_count) >= 32'(MIN_GATE_CYC)));

endmodule

// File: tb/recip_gate_engine_bench.sv
module recip_gate_engine_bench;
    localparam int MIN_G  = 40;
    localparam int FIRST  = 30;
    localparam int LATE   = 50;
    localparam int RW     = $clog2(MIN_G + LATE + 1);

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic          hf_sel = 1'b0;
    logic          start = 1'b0;
    logic          gen_en = 1'b0;
    logic          gen_lvl = 1'b0;
    logic          man_lvl = 1'b0;
    int            gen_per = 4;
    int            gen_cnt = 0;
    logic          evt_in;
    logic [RW-1:0] evt_count;
    logic [RW-1:0] ref_count;
    logic          psc_hf;
    logic [8:0]    psc_factor;
    logic          done;
    logic          no_signal;

    int checks = 0;
    int errors = 0;

    always #10 clk = ~clk;

    assign evt_in = gen_en ? gen_lvl : man_lvl;

    always begin
        @(negedge clk);
        #1;
        if (!gen_en) begin
            gen_cnt = 0;
            gen_lvl = 1'b0;
        end else begin
            gen_lvl = ((gen_cnt % gen_per) < (gen_per / 2));
            gen_cnt = gen_cnt + 1;
        end
    end

    recip_gate_engine #(
        .MIN_GATE_CYC (MIN_G),
        .FIRST_TO_CYC (FIRST),
        .LATE_TO_CYC  (LATE)
    ) u_recip_gate_engine (
        .clk        (clk),
        .rst        (rst),
        .evt_in     (evt_in),
        .hf_sel     (hf_sel),
        .start      (start),
        .evt_count  (evt_count),
        .ref_count  (ref_count),
        .psc_hf     (psc_hf),
        .psc_factor (psc_factor),
        .done       (done),
        .no_signal  (no_signal)
    );

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic pulse_start(input logic hf);
        @(negedge clk);
        hf_sel = hf;
        start  = 1'b1;
        @(negedge clk);
        start  = 1'b0;
    endtask

    task automatic wait_done(output bit got);
        got = 1'b0;
        for (int i = 0; i < 500; i++) begin
            @(negedge clk);
            if (done) begin
                got = 1'b1;
                break;
            end
        end
    endtask

    task automatic measure(input int per, input logic hf);
        bit got;
        int n;
        int ev, rv;
        gen_en = 1'b0;
        gen_per = per;
        pulse_start(hf);
        chk(ref_count == 0 && evt_count == 0, "R5 clear", int'(ref_count), 0);
        gen_en = 1'b1;
        hf_sel = ~hf;
        wait_done(got);
        n = (MIN_G + per - 1) / per;
        chk(got, "R3 done seen", int'(got), 1);
        chk(int'(evt_count) == n, "R2 evt_count", int'(evt_count), n);
        chk(int'(ref_count) == n * per, "R3 ref_count", int'(ref_count), n * per);
        chk(psc_hf == hf, "R8 psc_hf", int'(psc_hf), int'(hf));
        chk(int'(psc_factor) == (hf ? 256 : 10), "R8 psc_factor",
            int'(psc_factor), hf ? 256 : 10);
        ev = int'(evt_count);
        rv = int'(ref_count);
        @(negedge clk);
        chk(done == 1'b0, "R4 done one cycle", int'(done), 0);
        repeat (5) @(negedge clk);
        chk(int'(evt_count) == ev && int'(ref_count) == rv, "R4 hold evt",
            int'(evt_count), ev);
        gen_en = 1'b0;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        errors++;
        $display("FAIL watchdog actual=%0d expected=%0d", 200000, 0);
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        bit got;
        int k;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        // R1 reset state
        chk(done == 0 && no_signal == 0, "R1 flags", int'({done, no_signal}), 0);
        chk(evt_count == 0 && ref_count == 0, "R1 counts", int'(ref_count), 0);
        chk(psc_hf == 0 && psc_factor == 10, "R1 prescaler", int'(psc_factor), 10);

        // R2 R3 R4 R8 period sweep
        for (int p = 2; p <= 45; p++) measure(p, logic'(p % 2));

        // R6 first-edge timeout
        gen_en = 1'b0;
        man_lvl = 1'b0;
        pulse_start(1'b1);
        k = 0;
        while (!no_signal && k < 200) begin
            @(negedge clk);
            k++;
        end
        chk(k == FIRST, "R6 first timeout cycles", k, FIRST);
        chk(evt_count == 0 && ref_count == 0, "R6 counts zero", int'(ref_count), 0);
        // R9 sticky across re-arm, then R6 auto re-arm measures
        hf_sel = 1'b0;
        repeat (FIRST + 5) @(negedge clk);
        chk(no_signal == 1'b1, "R9 still no_signal", int'(no_signal), 1);
        gen_per = 5;
        gen_en = 1'b1;
        wait_done(got);
        chk(got, "R6 re-arm done", int'(got), 1);
        chk(int'(ref_count) == 40 && int'(evt_count) == 8, "R6 re-arm ref",
            int'(ref_count), 40);
        chk(psc_factor == 10, "R8 resampled on re-arm", int'(psc_factor), 10);
        @(negedge clk);
        chk(no_signal == 1'b0, "R9 cleared by done", int'(no_signal), 0);
        gen_en = 1'b0;

        // R7 closing-edge timeout with a single isolated edge
        pulse_start(1'b0);
        man_lvl = 1'b1;
        k = 0;
        while (!no_signal && k < 300) begin
            @(negedge clk);
            k++;
            if (k == 3) man_lvl = 1'b0;
        end
        chk(k == MIN_G + LATE + 3, "R7 late timeout cycles", k, MIN_G + LATE + 3);
        chk(evt_count == 0 && ref_count == 0, "R7 counts zero", int'(ref_count), 0);
        chk(done == 1'b0, "R7 no done", int'(done), 0);

        // R5 restart mid-gate
        gen_per = 7;
        pulse_start(1'b0);
        chk(no_signal == 1'b0, "R5 start clears no_signal", int'(no_signal), 1'b0);
        gen_en = 1'b1;
        repeat (20) @(negedge clk);
        chk(ref_count != 0, "R5 gate running", int'(ref_count), 1);
        pulse_start(1'b1);
        chk(ref_count == 0 && evt_count == 0, "R5 mid clear", int'(ref_count), 0);
        hf_sel = 1'b0;
        wait_done(got);
        chk(got, "R5 done after restart", int'(got), 1);
        chk(int'(evt_count) == 6 && int'(ref_count) == 42, "R5 restart counts",
            int'(ref_count), 42);
        chk(psc_hf == 1'b1 && psc_factor == 256, "R8 latched despite hf_sel change",
            int'(psc_factor), 256);
        // R10 bound holds in every result seen
        chk(int'(ref_count) <= MIN_G + LATE, "R10 ref bound", int'(ref_count), MIN_G + LATE);
        gen_en = 1'b0;

        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule